// File: doc/BRIEF.md
# AES-128 Inverse Cipher Pipeline

This block turns AES-128 ciphertext back into plaintext at a rate of one 128-bit block per clock. The inverse cipher is fully unrolled. An entry stage adds the last round key to the incoming block. Ten round stages follow it, and each one has its own register. Every round stage rotates row r of the state right by r byte positions, replaces each byte through the inverse substitution box, XORs in its round key, and then mixes each column with the inverse mixing matrix. The tenth round stage skips the column mixing. Its output is the plaintext.

The eleven round keys come in on one wide bus. They are the round keys an encryptor produces for the same cipher key; this block does not expand keys. A valid flag travels alongside each block. No stage stalls, so a continuous stream of ciphertext can be decrypted with no gaps, and any gaps in the input appear at the output in the same cycles. The block has no state machine. Each stage is one data register and one valid flop. The valid flops clear on reset; the data registers load every cycle.

Top module: `aes128_dec_pipe`

## Requirements
- R1: While reset is asserted, and during the first 11 clock edges after it is released, `out_valid` is low.
- R2: `out_valid` sampled at a clock edge equals `in_valid` sampled 11 edges earlier, counting only edges after reset release.
- R3: State byte n (n = 0..15) occupies bits [127-8n:120-8n], and the bytes are grouped into columns of four consecutive bytes. With this layout, the round keys of cipher key 2b7e151628aed2a6abf7158809cf4f3c and ciphertext 3925841d02dc09fbdc118597196a0b32 yield plaintext 3243f6a8885a308d313198a2e0370734.
- R4: Round key i (0..10) occupies bits [128i+127:128i] of `round_keys`. Key 10 is applied first and key 0 last. For any key and any plaintext, standard AES-128 encryption followed by this block returns the plaintext, provided `round_keys` is held stable while blocks are in flight.
- R5: Blocks presented on consecutive cycles come out on consecutive cycles, in their input order, each one correct.
- R6: A cycle with `in_valid` low produces no `out_valid` 11 edges later. The data presented in such a cycle has no effect on any other block's result.
- R7: All-zero and all-ones keys and plaintexts are handled like any other value.
- R8: Asserting reset while blocks are in flight discards all of them: none of them appears at the output after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | Ciphertext on `ct_in` is valid this cycle |
| ct_in | input | 128 | Ciphertext block |
| round_keys | input | 1408 | Eleven round keys, key i at bits [128i+127:128i] |
| out_valid | output | 1 | Plaintext on `pt_out` is valid |
| pt_out | output | 128 | Decrypted plaintext block |

## Verification
A block accepted at a clock edge has its plaintext and its valid flag due exactly 11 edges later, and no other result is produced. The scoreboard records the cycle in which each result is due. A monitor on the falling edge compares the head of the queue only in that cycle, so a result that arrives early, arrives late or is missing shows up as a timing failure under R2. Any `out_valid` that no queued entry accounts for is reported as an unexpected output. Round keys change only after the queue has drained, and the reset test empties the queue and then checks `out_valid` on each of the cycles that follow release.

// File: rtl/aes_dec_pkg.sv
`timescale 1ns/1ps
package aes_dec_pkg;
    localparam int BLK_W    = 128;
    localparam int N_ROUNDS = 10;

    typedef logic [7:0] byte_t;

    // rotate an 8-bit value left by k positions
    function automatic byte_t rotl8(byte_t x, int k);
        return byte_t'((x << k) | (x >> (8 - k)));
    endfunction

    // multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t p;
        byte_t x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254; zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    // undo the affine map of the forward substitution
    function automatic byte_t inv_affine(byte_t a);
        return rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    endfunction

    function automatic byte_t inv_sbox(byte_t a);
        return gf_inv(inv_affine(a));
    endfunction
endpackage

// File: rtl/aes_inv_sub_shift.sv
`timescale 1ns/1ps
module aes_inv_sub_shift
    import aes_dec_pkg::*;
#(
    parameter int BLK = BLK_W
) (
    input  logic [BLK-1:0] din,
    output logic [BLK-1:0] dout
);
    localparam int NCOL = BLK / 32;

    // row r of column c takes row r of column (c - r) mod NCOL, then the inverse S-box
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int SRC_COL = (c + NCOL - r) % NCOL;
            assign dout[BLK-1-8*(r+4*c) -: 8] = inv_sbox(din[BLK-1-8*(r+4*SRC_COL) -: 8]);
        end
    end
endmodule

// File: rtl/aes_inv_mixcol.sv
`timescale 1ns/1ps
module aes_inv_mixcol
    import aes_dec_pkg::*;
(
    input  logic [31:0] col_in,
    output logic [31:0] col_out
);
    byte_t a0, a1, a2, a3;

    assign a0 = col_in[31:24];
    assign a1 = col_in[23:16];
    assign a2 = col_in[15:8];
    assign a3 = col_in[7:0];

    always_comb begin
        col_out[31:24] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        col_out[23:16] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        col_out[15:8]  = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        col_out[7:0]   = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end

    // coefficients 0e^0b^0d^09 = 01, so the byte-wise XOR of a column is preserved (R4)
    always_comb begin
        if (!$isunknown(col_in)) begin
            assert_mix_parity_R4: assert ((col_out[31:24] ^ col_out[23:16] ^ col_out[15:8] ^ col_out[7:0])
                                          == (a0 ^ a1 ^ a2 ^ a3));
        end
    end
endmodule

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
module aes_inv_round
    import aes_dec_pkg::*;
#(
    parameter int BLK   = BLK_W,
    parameter bit FINAL = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [BLK-1:0] in_state,
    input  logic [BLK-1:0] round_key,
    output logic           out_vld,
    output logic [BLK-1:0] out_state
);
    localparam int NCOL = BLK / 32;

    logic [BLK-1:0] shifted;
    logic [BLK-1:0] keyed;
    logic [BLK-1:0] mixed;

    aes_inv_sub_shift #(.BLK(BLK)) u_sub_shift (
        .din  (in_state),
        .dout (shifted)
    );

    assign keyed = shifted ^ round_key;

    if (FINAL) begin : g_nomix
        assign mixed = keyed;
    end else begin : g_mix
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            aes_inv_mixcol u_mixcol (
                .col_in  (keyed[BLK-1-32*c -: 32]),
                .col_out (mixed[BLK-1-32*c -: 32])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    always_ff @(posedge clk) begin
        out_state <= mixed;
    end
endmodule

// File: rtl/aes128_dec_pipe.sv
`timescale 1ns/1ps
module aes128_dec_pipe
    import aes_dec_pkg::*;
#(
    parameter int BLK = BLK_W,
    parameter int NR  = N_ROUNDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [BLK-1:0]        ct_in,
    input  logic [(NR+1)*BLK-1:0] round_keys,
    output logic                  out_valid,
    output logic [BLK-1:0]        pt_out
);
    localparam int LAT   = NR + 1;
    localparam int CNT_W = $clog2(LAT + 1);

    logic           vld [0:NR];
    logic [BLK-1:0] st  [0:NR];

    // entry stage: add the last round key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= in_valid;
    end

    always_ff @(posedge clk) begin
        st[0] <= ct_in ^ round_keys[NR*BLK +: BLK];
    end

    // round stage g+1 consumes round key NR-1-g; the last one skips column mixing
    for (genvar g = 0; g < NR; g++) begin : g_round
        aes_inv_round #(
            .BLK   (BLK),
            .FINAL (g == NR - 1)
        ) u_round (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_vld    (vld[g]),
            .in_state  (st[g]),
            .round_key (round_keys[(NR-1-g)*BLK +: BLK]),
            .out_vld   (vld[g+1]),
            .out_state (st[g+1])
        );
    end

    assign out_valid = vld[NR];
    assign pt_out    = st[NR];

    // edges seen since reset release, saturating at LAT
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_rst <= '0;
        else if (since_rst != CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CNT_W'(LAT)) |-> !out_valid);

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CNT_W'(LAT)) |-> (out_valid == $past(in_valid, 11)));

    assert_known_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(pt_out));
endmodule

// File: tb/test_aes128_dec_pipe.sv
`timescale 1ns/1ps
module test_aes128_dec_pipe;
    logic          clk;
    logic          rst_n;
    logic          in_valid;
    logic [127:0]  ct_in;
    logic [1407:0] round_keys;
    logic          out_valid;
    logic [127:0]  pt_out;

    aes128_dec_pipe i_aes128_dec_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .ct_in      (ct_in),
        .round_keys (round_keys),
        .out_valid  (out_valid),
        .pt_out     (pt_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [127:0] exp_q [$];
    int           due_q [$];
    string        tag_q [$];

    logic [7:0] sbox_tab [256];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model: forward AES-128 ----------------
    function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= x;
            x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [7:0] tb_rotl(logic [7:0] x, int k);
        return (x << k) | (x >> (8 - k));
    endfunction

    function automatic void build_sbox();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv;
            inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (tb_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            sbox_tab[a] = inv ^ tb_rotl(inv, 1) ^ tb_rotl(inv, 2) ^ tb_rotl(inv, 3)
                          ^ tb_rotl(inv, 4) ^ 8'h63;
        end
    endfunction

    function automatic logic [1407:0] expand_key(logic [127:0] key);
        logic [31:0]   w [44];
        logic [31:0]   t;
        logic [7:0]    rc;
        logic [1407:0] r;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sbox_tab[t[31:24]], sbox_tab[t[23:16]], sbox_tab[t[15:8]], sbox_tab[t[7:0]]}
                    ^ {rc, 24'h0};
                rc = tb_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int k = 0; k < 11; k++) r[128*k +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
        return r;
    endfunction

    function automatic logic [127:0] encrypt(logic [127:0] pt, logic [1407:0] rks);
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [127:0] st;
        st = pt ^ rks[127:0];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int n = 0; n < 16; n++) t[n] = sbox_tab[st[127-8*n -: 8]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[r+4*c] = t[r+4*((c+r)%4)];
            if (rnd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    t[4*c]   = tb_mul(s[4*c], 8'h02) ^ tb_mul(s[4*c+1], 8'h03) ^ s[4*c+2] ^ s[4*c+3];
                    t[4*c+1] = s[4*c] ^ tb_mul(s[4*c+1], 8'h02) ^ tb_mul(s[4*c+2], 8'h03) ^ s[4*c+3];
                    t[4*c+2] = s[4*c] ^ s[4*c+1] ^ tb_mul(s[4*c+2], 8'h02) ^ tb_mul(s[4*c+3], 8'h03);
                    t[4*c+3] = tb_mul(s[4*c], 8'h03) ^ s[4*c+1] ^ s[4*c+2] ^ tb_mul(s[4*c+3], 8'h02);
                end
            end else begin
                for (int n = 0; n < 16; n++) t[n] = s[n];
            end
            for (int n = 0; n < 16; n++) st[127-8*n -: 8] = t[n];
            st = st ^ rks[128*rnd +: 128];
        end
        return st;
    endfunction

    // ---------------- driver ----------------
    task automatic push_block(input logic [127:0] ct, input logic [127:0] pt, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        ct_in    = ct;
        exp_q.push_back(pt);
        due_q.push_back(cyc + 11);
        tag_q.push_back(tag);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        ct_in    = {$urandom, $urandom, $urandom, $urandom};
    endtask

    task automatic drain();
        idle_cycle();
        while (due_q.size() != 0) idle_cycle();
        idle_cycle();
    endtask

    task automatic load_key(input logic [127:0] key);
        drain();
        round_keys = expand_key(key);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (due_q.size() != 0 && due_q[0] == cyc) begin
                chk(out_valid === 1'b1, "R2", "out_valid on due cycle", {127'b0, out_valid}, 128'h1);
                chk(pt_out === exp_q[0], tag_q[0], "plaintext", pt_out, exp_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end else if (out_valid !== 1'b0) begin
                chk(1'b0, "R6", "unexpected out_valid", {127'b0, out_valid}, 128'h0);
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [127:0] key;
        logic [127:0] pt;
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        ct_in      = '0;
        round_keys = '0;
        build_sbox();

        // R1: quiet during and after reset
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid in reset", {127'b0, out_valid}, 128'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R1", "out_valid after release", {127'b0, out_valid}, 128'h0);
        end

        // R3: known answer
        load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
        push_block(128'h3925841d02dc09fbdc118597196a0b32, 128'h3243f6a8885a308d313198a2e0370734, "R3");
        drain();

        // R4 and R5: random keys, back-to-back random plaintexts
        for (int k = 0; k < 3; k++) begin
            key = {$urandom, $urandom, $urandom, $urandom};
            load_key(key);
            for (int i = 0; i < 24; i++) begin
                pt = {$urandom, $urandom, $urandom, $urandom};
                push_block(encrypt(pt, round_keys), pt, (i == 0) ? "R4" : "R5");
            end
        end
        drain();

        // R6: bubbles carrying random data
        key = {$urandom, $urandom, $urandom, $urandom};
        load_key(key);
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                pt = {$urandom, $urandom, $urandom, $urandom};
                push_block(encrypt(pt, round_keys), pt, "R6");
            end else begin
                idle_cycle();
            end
        end
        drain();

        // R7: degenerate keys and data
        load_key(128'h0);
        push_block(encrypt(128'h0, round_keys), 128'h0, "R7");
        push_block(encrypt({128{1'b1}}, round_keys), {128{1'b1}}, "R7");
        load_key({128{1'b1}});
        push_block(encrypt(128'h0, round_keys), 128'h0, "R7");
        push_block(encrypt({128{1'b1}}, round_keys), {128{1'b1}}, "R7");
        drain();

        // R8: reset while blocks are in flight
        for (int i = 0; i < 5; i++) begin
            pt = {$urandom, $urandom, $urandom, $urandom};
            push_block(encrypt(pt, round_keys), pt, "R8");
        end
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R8", "flushed block reappeared", {127'b0, out_valid}, 128'h0);
        end

        // traffic still correct after the flush
        pt = {$urandom, $urandom, $urandom, $urandom};
        push_block(encrypt(pt, round_keys), pt, "R8");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule